// File: doc/BRIEF.md
# Decoupled Instruction Prefetch Unit

This block is the front end of an instruction fetch path. It keeps fetching 32-bit longwords from a local instruction bus on its own schedule, whatever the decode stage is doing. A first stage holds the next prefetch address and steps it forward by four bytes. A second stage holds one bus request until the bus grants it. Words that come back go into a three-entry decoupling buffer. When that buffer is empty and the consumer is ready, a word goes straight to the output in the cycle it arrives.

A redirect input loads a new target address and empties the buffer. Any response that belongs to a fetch granted before or during the redirect cycle is discarded, even one that arrives in the redirect cycle itself. A new fetch is started only if the buffered words plus the live fetches in flight leave room for its data. Because of this, returned data can never overflow the buffer while the consumer stalls. The bus returns responses in the order the requests were granted, and the latency of each response can vary.

Top module: `insn_prefetch`

## Requirements
- R1: While reset is high, bus_req and out_valid are low. The first request issued after reset carries the reset vector with its two low bits cleared.
- R2: Every address placed on bus_addr has bits [1:0] equal to 00. Within one fetch stream, each granted address is the previously granted address plus 4.
- R3: A redirect in cycle t takes the target (low two bits cleared) as the next fetch address. bus_req is low in cycle t+1. If nothing is buffered and fewer than four fetches are in flight, bus_req is high in cycle t+2 with the target address.
- R4: Buffered words plus live granted fetches plus the held request never exceed three. With the consumer stalled and an empty pipe, exactly three fetches are granted, and then bus_req stays low.
- R5: When the buffer is empty, a kept response with out_ready high appears on out_valid/out_data in the same cycle as bus_rvalid.
- R6: If out_valid is high, out_ready is low and there is no redirect, then in the next cycle out_valid stays high with an unchanged out_data, unless that next cycle is itself a redirect.
- R7: out_valid is low during a redirect cycle, and the buffer is emptied. The first word accepted after a redirect is the memory word at the aligned target.
- R8: Responses to fetches granted in or before a redirect cycle never reach the output. This includes a response that arrives in the redirect cycle.
- R9: Once raised, bus_req and bus_addr hold until bus_gnt, unless a redirect withdraws the request.
- R10: The accepted output stream equals the memory words at consecutive ascending aligned addresses from the latest start point (reset vector or redirect target).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reset_vec | input | 32 | Start address loaded at reset |
| redir_valid | input | 1 | Redirect strobe |
| redir_target | input | 32 | Redirect destination address |
| bus_req | output | 1 | Fetch request to the instruction bus |
| bus_addr | output | 32 | Fetch address, longword aligned |
| bus_gnt | input | 1 | Bus accepts the current request |
| bus_rvalid | input | 1 | Response longword valid (in grant order) |
| bus_rdata | input | 32 | Response longword |
| out_valid | output | 1 | Longword available to the decode stage |
| out_data | output | 32 | Longword toward decode |
| out_ready | input | 1 | Decode stage accepts the longword |

## Verification
The assertions check the per-cycle rules on every cycle. These rules are: address alignment, holding a request until its grant, the gap of one idle cycle after a redirect, the occupancy limit, output hold under backpressure, silence of the output during a redirect, and responses only arriving while fetches are owed. Other behaviour only shows up in the bench's scenarios, because it spans many cycles and needs a memory model. That behaviour covers the content and order of the delivered stream, the dropping of stale words (a redirect is forced onto a returning response), the exact count of three fetches under a long stall, and same-cycle bypass under random latency.

// File: rtl/pf_pkg.sv
package pf_pkg;
    localparam int unsigned PF_AW           = 32;
    localparam int unsigned PF_DW           = 32;
    localparam int unsigned PF_DEPTH        = 3;
    localparam int unsigned PF_MAX_INFLIGHT = 4;

    typedef logic [PF_AW-1:0] pf_addr_t;

    // Clear the byte-offset bits of a fetch address.
    function automatic pf_addr_t pf_align(input pf_addr_t a);
        return a & ~pf_addr_t'(3);
    endfunction
endpackage

// File: rtl/pf_issue.sv
// Address-generation and fetch-request stages.
module pf_issue #(
    parameter int unsigned AW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] reset_vec,
    input  logic          redir_valid,
    input  logic [AW-1:0] redir_target,
    input  logic          launch_ok,
    input  logic          gnt_fire,
    input  logic          bus_gnt,
    output logic          bus_req,
    output logic [AW-1:0] bus_addr
);
    localparam logic [AW-1:0] LOW_MASK = AW'(3);
    localparam logic [AW-1:0] STRIDE   = AW'(4);

    typedef struct packed {
        logic [AW-1:0] pc;
        logic          req_v;
        logic [AW-1:0] req_a;
    } issue_st_t;

    issue_st_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        if (redir_valid) begin
            st_d.pc    = redir_target & ~LOW_MASK;
            st_d.req_v = 1'b0;
        end else if ((!st_q.req_v || gnt_fire) && launch_ok) begin
            st_d.req_v = 1'b1;
            st_d.req_a = st_q.pc;
            st_d.pc    = st_q.pc + STRIDE;
        end else if (gnt_fire) begin
            st_d.req_v = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.pc    <= reset_vec & ~LOW_MASK;
            st_q.req_v <= 1'b0;
            st_q.req_a <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign bus_req  = st_q.req_v;
    assign bus_addr = st_q.req_a;

    assert_reset_idle_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !bus_req);

    assert_addr_align_R2: assert property (@(posedge clk) disable iff (rst)
        bus_req |-> (bus_addr[1:0] == 2'b00));

    assert_redir_gap_R3: assert property (@(posedge clk) disable iff (rst)
        redir_valid |=> !bus_req);

    assert_req_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (bus_req && !bus_gnt && !redir_valid) |=> (bus_req && $stable(bus_addr)));
endmodule

// File: rtl/pf_track.sv
// Counts granted fetches still owed by the bus, and how many of them are stale.
module pf_track #(
    parameter int unsigned MAX_INFLIGHT = 4,
    localparam int unsigned IW = $clog2(MAX_INFLIGHT + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          redir_valid,
    input  logic          gnt_fire,
    input  logic          rsp_valid,
    output logic [IW-1:0] inflight_q,
    output logic [IW-1:0] stale_q,
    output logic [IW-1:0] inflight_d,
    output logic [IW-1:0] stale_d
);
    typedef struct packed {
        logic [IW-1:0] inflight;
        logic [IW-1:0] stale;
    } trk_st_t;

    trk_st_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        st_d.inflight = st_q.inflight + IW'(gnt_fire) - IW'(rsp_valid);
        if (redir_valid) begin
            st_d.stale = st_d.inflight;
        end else if (rsp_valid && (st_q.stale != '0)) begin
            st_d.stale = st_q.stale - IW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign inflight_q = st_q.inflight;
    assign stale_q    = st_q.stale;
    assign inflight_d = st_d.inflight;
    assign stale_d    = st_d.stale;

    assert_rsp_owed_R8: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> (inflight_q != '0));

    assert_stale_subset_R8: assert property (@(posedge clk) disable iff (rst)
        stale_q <= inflight_q);

    assert_inflight_cap_R4: assert property (@(posedge clk) disable iff (rst)
        inflight_q <= IW'(MAX_INFLIGHT));
endmodule

// File: rtl/pf_fifo.sv
// Small circular decoupling buffer with flush.
module pf_fifo #(
    parameter int unsigned DEPTH = 3,
    parameter int unsigned DW    = 32,
    localparam int unsigned CW = $clog2(DEPTH + 1),
    localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          flush,
    input  logic          push,
    input  logic          pop,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] head,
    output logic          empty,
    output logic [CW-1:0] cnt_q,
    output logic [CW-1:0] cnt_d
);
    typedef struct packed {
        logic [PW-1:0] rd;
        logic [PW-1:0] wr;
        logic [CW-1:0] cnt;
    } fifo_st_t;

    fifo_st_t st_q, st_d;
    logic [DW-1:0] mem_q [DEPTH];
    logic [DW-1:0] mem_d [DEPTH];

    function automatic logic [PW-1:0] wrap_inc(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
    endfunction

    always_comb begin
        st_d  = st_q;
        mem_d = mem_q;
        if (flush) begin
            st_d = '0;
        end else begin
            if (pop) st_d.rd = wrap_inc(st_q.rd);
            if (push) begin
                mem_d[st_q.wr] = wdata;
                st_d.wr        = wrap_inc(st_q.wr);
            end
            st_d.cnt = st_q.cnt + CW'(push) - CW'(pop);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
        mem_q <= mem_d;
    end

    assign head  = mem_q[st_q.rd];
    assign empty = (st_q.cnt == '0);
    assign cnt_q = st_q.cnt;
    assign cnt_d = st_d.cnt;

    assert_no_overflow_R4: assert property (@(posedge clk) disable iff (rst)
        (push && !flush) |-> ((st_q.cnt < CW'(DEPTH)) || pop));

    assert_no_underflow_R4: assert property (@(posedge clk) disable iff (rst)
        pop |-> !empty);
endmodule

// File: rtl/insn_prefetch.sv
// Decoupled instruction prefetch unit: top level.
module insn_prefetch
    import pf_pkg::*;
#(
    parameter int unsigned AW           = PF_AW,
    parameter int unsigned DW           = PF_DW,
    parameter int unsigned DEPTH        = PF_DEPTH,
    parameter int unsigned MAX_INFLIGHT = PF_MAX_INFLIGHT
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] reset_vec,
    input  logic          redir_valid,
    input  logic [AW-1:0] redir_target,
    output logic          bus_req,
    output logic [AW-1:0] bus_addr,
    input  logic          bus_gnt,
    input  logic          bus_rvalid,
    input  logic [DW-1:0] bus_rdata,
    output logic          out_valid,
    output logic [DW-1:0] out_data,
    input  logic          out_ready
);
    localparam int unsigned IW = $clog2(MAX_INFLIGHT + 1);
    localparam int unsigned CW = $clog2(DEPTH + 1);
    localparam int unsigned OW = 8;

    logic          gnt_fire;
    logic          launch_ok;
    logic          rsp_keep;
    logic          buf_empty;
    logic          buf_push;
    logic          buf_pop;
    logic [DW-1:0] buf_head;
    logic [CW-1:0] buf_cnt_q;
    logic [CW-1:0] buf_cnt_d;
    logic [IW-1:0] inflight_q;
    logic [IW-1:0] stale_q;
    logic [IW-1:0] inflight_d;
    logic [IW-1:0] stale_d;
    logic [OW-1:0] occ_next;

    assign gnt_fire = bus_req & bus_gnt;

    // A response is kept only if it is not owed to an older stream.
    assign rsp_keep = bus_rvalid && (stale_q == '0) && !redir_valid;

    // Output: buffer head first, otherwise bypass the arriving word.
    always_comb begin
        out_valid = !redir_valid && (!buf_empty || rsp_keep);
        out_data  = buf_empty ? bus_rdata : buf_head;
        buf_pop   = !redir_valid && !buf_empty && out_ready;
        buf_push  = rsp_keep && !(buf_empty && out_ready);
    end

    // Credit: buffered words plus live owed fetches must leave room.
    always_comb begin
        occ_next  = OW'(buf_cnt_d) + OW'(inflight_d) - OW'(stale_d);
        launch_ok = (occ_next < OW'(DEPTH)) && (inflight_d < IW'(MAX_INFLIGHT));
    end

    pf_issue #(.AW(AW)) u_issue (
        .clk          (clk),
        .rst          (rst),
        .reset_vec    (reset_vec),
        .redir_valid  (redir_valid),
        .redir_target (redir_target),
        .launch_ok    (launch_ok),
        .gnt_fire     (gnt_fire),
        .bus_gnt      (bus_gnt),
        .bus_req      (bus_req),
        .bus_addr     (bus_addr)
    );

    pf_track #(.MAX_INFLIGHT(MAX_INFLIGHT)) u_track (
        .clk         (clk),
        .rst         (rst),
        .redir_valid (redir_valid),
        .gnt_fire    (gnt_fire),
        .rsp_valid   (bus_rvalid),
        .inflight_q  (inflight_q),
        .stale_q     (stale_q),
        .inflight_d  (inflight_d),
        .stale_d     (stale_d)
    );

    pf_fifo #(.DEPTH(DEPTH), .DW(DW)) u_fifo (
        .clk   (clk),
        .rst   (rst),
        .flush (redir_valid),
        .push  (buf_push),
        .pop   (buf_pop),
        .wdata (bus_rdata),
        .head  (buf_head),
        .empty (buf_empty),
        .cnt_q (buf_cnt_q),
        .cnt_d (buf_cnt_d)
    );

    assert_occupancy_R4: assert property (@(posedge clk) disable iff (rst)
        (OW'(buf_cnt_q) + OW'(inflight_q) - OW'(stale_q) + OW'(bus_req)) <= OW'(DEPTH));

    assert_out_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready && !redir_valid) |=>
        (redir_valid || (out_valid && $stable(out_data))));

    assert_redir_silent_R7: assert property (@(posedge clk) disable iff (rst)
        redir_valid |-> !out_valid);

    assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !out_valid);
endmodule

// File: tb/insn_prefetch_tb.sv
`timescale 1ns/1ps
module insn_prefetch_tb;
    localparam logic [31:0] RV = 32'h0000_1F02;

    logic        clk = 1'b0;
    logic        rst;
    logic        redir_valid;
    logic [31:0] redir_target;
    logic        bus_req;
    logic [31:0] bus_addr;
    logic        bus_gnt;
    logic        bus_rvalid;
    logic [31:0] bus_rdata;
    logic        out_valid;
    logic [31:0] out_data;
    logic        out_ready;

    always #2.5 clk = ~clk;

    insn_prefetch u_dut (
        .clk          (clk),
        .rst          (rst),
        .reset_vec    (RV),
        .redir_valid  (redir_valid),
        .redir_target (redir_target),
        .bus_req      (bus_req),
        .bus_addr     (bus_addr),
        .bus_gnt      (bus_gnt),
        .bus_rvalid   (bus_rvalid),
        .bus_rdata    (bus_rdata),
        .out_valid    (out_valid),
        .out_data     (out_data),
        .out_ready    (out_ready)
    );

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int grants = 0;
    int gnt_pct, ready_pct, redir_pct, redir_rv_pct, lat_max;
    bit bypass_chk = 0;
    bit force_redir = 0;
    logic [31:0] force_tgt;

    // Bus responder queue: granted addresses and the cycle each is due.
    logic [31:0] rq_addr[$];
    int          rq_due[$];

    // Scoreboard state for the expected streams.
    logic [31:0] exp_out, exp_fetch;
    bit out_fresh, fetch_fresh, first_live;
    bit p_req, p_gnt, p_redir, p_ov, p_rdy;
    logic [31:0] p_addr, p_data;

    function automatic logic [31:0] mem_word(input logic [31:0] a);
        return {a[15:0], a[31:16]} ^ 32'hC3A5_0F1E;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic step();
        logic [31:0] tgt_al;
        @(negedge clk);
        cyc++;
        bus_gnt = !rst && bus_req && ($urandom_range(99) < gnt_pct);
        if (!rst && rq_addr.size() > 0 && rq_due[0] <= cyc) begin
            bus_rvalid = 1'b1;
            bus_rdata  = mem_word(rq_addr[0]);
        end else begin
            bus_rvalid = 1'b0;
            bus_rdata  = $urandom;
        end
        redir_valid = !rst && (force_redir ||
                      (bus_rvalid && ($urandom_range(99) < redir_rv_pct)) ||
                      ($urandom_range(99) < redir_pct));
        redir_target = force_redir ? force_tgt : $urandom;
        tgt_al = redir_target & 32'hFFFF_FFFC;
        out_ready = ($urandom_range(99) < ready_pct);
        #1;
        if (rst) begin
            check(!bus_req, "R1", "bus_req in reset", {31'd0, bus_req}, 32'd0);
            check(!out_valid, "R1", "out_valid in reset", {31'd0, out_valid}, 32'd0);
            rq_addr.delete(); rq_due.delete();
            exp_out = RV & 32'hFFFF_FFFC; exp_fetch = exp_out;
            out_fresh = 1; fetch_fresh = 1; first_live = 1;
            p_req = 0; p_gnt = 0; p_redir = 0; p_ov = 0; p_rdy = 0;
            return;
        end
        if (first_live) begin
            check(bus_req && bus_addr == (RV & 32'hFFFF_FFFC), "R1", "first request",
                  bus_addr, RV & 32'hFFFF_FFFC);
            first_live = 0;
        end
        if (bus_req)
            check(bus_addr[1:0] == 2'b00, "R2", "alignment", bus_addr, bus_addr & ~32'd3);
        if (p_req && !p_gnt && !p_redir)
            check(bus_req && bus_addr == p_addr, "R9", "request hold", bus_addr, p_addr);
        if (bus_gnt) begin
            check(bus_addr == exp_fetch, fetch_fresh ? "R3" : "R2", "granted address",
                  bus_addr, exp_fetch);
            exp_fetch += 4; fetch_fresh = 0;
        end
        if (redir_valid)
            check(!out_valid, "R7", "out_valid during redirect", {31'd0, out_valid}, 32'd0);
        if (p_ov && !p_rdy && !p_redir && !redir_valid)
            check(out_valid && out_data == p_data, "R6", "backpressure hold", out_data, p_data);
        if (bypass_chk && bus_rvalid && !redir_valid)
            check(out_valid && out_data == bus_rdata, "R5", "bypass", out_data, bus_rdata);
        if (out_valid && out_ready && !redir_valid) begin
            // R8: the first word after a redirect must be the target, never stale data.
            check(out_data == mem_word(exp_out), out_fresh ? "R8" : "R10", "stream word",
                  out_data, mem_word(exp_out));
            exp_out += 4; out_fresh = 0;
        end
        if (bus_gnt) begin
            rq_addr.push_back(bus_addr);
            rq_due.push_back(cyc + 1 + $urandom_range(lat_max));
            grants++;
        end
        if (bus_rvalid) begin
            void'(rq_addr.pop_front());
            void'(rq_due.pop_front());
        end
        p_req = bus_req; p_gnt = bus_gnt; p_addr = bus_addr; p_redir = redir_valid;
        p_ov = out_valid; p_rdy = out_ready; p_data = out_data;
        if (redir_valid) begin
            exp_out = tgt_al; exp_fetch = tgt_al; out_fresh = 1; fetch_fresh = 1;
        end
    endtask

    task automatic knobs(input int g, input int r, input int rd, input int rrv, input int lat);
        gnt_pct = g; ready_pct = r; redir_pct = rd; redir_rv_pct = rrv; lat_max = lat;
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        rst = 1; redir_valid = 0; redir_target = 0; bus_gnt = 0; bus_rvalid = 0;
        bus_rdata = 0; out_ready = 0; force_tgt = 0;
        knobs(0, 0, 0, 0, 0);
        // R1: reset state and first fetch address
        for (int i = 0; i < 4; i++) step();
        rst = 0;
        // Mixed traffic, no redirects: R2, R9, R10
        knobs(70, 70, 0, 0, 3);
        for (int i = 0; i < 300; i++) step();
        // Drain everything before the directed stall
        knobs(0, 100, 0, 0, 3);
        for (int i = 0; i < 12; i++) step();
        force_redir = 1; force_tgt = 32'h0002_0006;
        step();
        force_redir = 0;
        knobs(100, 0, 0, 0, 2);
        grants = 0;
        step();
        check(!bus_req, "R3", "idle cycle after redirect", {31'd0, bus_req}, 32'd0);
        step();
        check(bus_req && bus_addr == 32'h0002_0004, "R3", "target issued at t+2",
              bus_addr, 32'h0002_0004);
        for (int i = 0; i < 28; i++) step();
        check(grants == 3, "R4", "grants under stall", grants, 32'd3);
        check(!bus_req, "R4", "no request when full", {31'd0, bus_req}, 32'd0);
        // Consumer always ready: after the buffer drains, every word bypasses (R5)
        knobs(100, 100, 0, 0, 3);
        for (int i = 0; i < 20; i++) step();
        bypass_chk = 1;
        for (int i = 0; i < 200; i++) step();
        bypass_chk = 0;
        // Redirects landing on returning data (R8)
        knobs(80, 80, 0, 60, 4);
        for (int i = 0; i < 600; i++) step();
        // Fully random mix
        knobs(60, 60, 2, 25, 5);
        for (int i = 0; i < 4000; i++) step();
        finish_run();
    end
endmodule